// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is the logic core of a small programmable logic device: a wide AND plane whose connections are set by a configuration vector, followed by a fixed OR plane that gathers product terms into twelve sums. Every input line is presented to every product term in both its true and its inverted form. The configuration vector decides which of those literals each product term uses.

The array takes fourteen dedicated inputs and twelve feedback lines, which come back from the output cells downstream. It produces twelve sums, one for each output cell. The outputs are not all the same width: the number of product terms behind each sum ranges from eight to sixteen.

The outputs depend only on the input lines and the configuration vector, through combinational logic. There is no clock and no state. The configuration is held static by the surrounding logic.

Top module: `sop_array`

## Requirements
- R1: Line index k in 0..13 is dedicated input `ded_in[k]`, and line index 14+j is feedback input `fb_in[j]`, giving 26 lines.
- R2: Product term t owns configuration bits `cfg_fuses[t*52 +: 52]`. Within that slice, bit 2k connects the true form of line k and bit 2k+1 connects its inverted form. A bit value of 1 means connected.
- R3: A product term with no connection bit set evaluates to 1.
- R4: A product term with both connection bits of any one line set evaluates to 0 for every input value.
- R5: The product terms per output, from output 0 to 11, are 8, 8, 10, 12, 14, 16, 16, 14, 12, 10, 8, 8. They are numbered consecutively, starting with output 0, which gives 136 terms in total.
- R6: Output o is the OR of its own allocated terms only. Terms that belong to other outputs have no effect on it.
- R7: A product term is the AND of all its connected literals.
- R8: The outputs follow changes on the inputs and the configuration with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ded_in | input | 14 | Dedicated input lines (lines 0..13) |
| fb_in | input | 12 | Feedback lines from output cells (lines 14..25) |
| cfg_fuses | input | 7072 | Static connection map, 52 bits per product term |
| sum_out | output | 12 | OR sums, one per output cell |

## Verification
An unprogrammed map is applied first, under several input patterns, to show that empty terms read high on every output. Single-literal terms are then swept over all 26 lines, in both polarities and with both input values, on every output. This tells a correct line order and polarity from a swapped or mis-indexed one. For each output in turn, every term is stuck low and then released one at a time. This pins down each group's exact size and its boundaries, and a term counted into the wrong output shows up as a wrong sum. Sparse random maps with random inputs, compared against an arithmetic model, exercise AND and OR together.

// File: rtl/sop_pkg.sv
package sop_pkg;
    localparam int N_DED  = 14;
    localparam int N_FB   = 12;
    localparam int N_OUT  = 12;
    localparam int N_LINE = N_DED + N_FB;
    localparam int N_LIT  = 2 * N_LINE;

    // Mirrored allocation: 8,8,10,12,14,16 then the same in reverse
    function automatic int terms_of(input int o);
        int idx;
        idx = (o < N_OUT / 2) ? o : (N_OUT - 1 - o);
        return (idx == 0) ? 8 : (8 + 2 * (idx - 1));
    endfunction

    function automatic int base_of(input int o);
        int acc;
        acc = 0;
        for (int i = 0; i < o; i++) acc += terms_of(i);
        return acc;
    endfunction

    localparam int N_TERM = base_of(N_OUT);
    localparam int FUSE_W = N_TERM * N_LIT;

    typedef struct packed {
        logic [N_FB-1:0]  fb;
        logic [N_DED-1:0] ded;
    } line_bus_t;
endpackage

// File: rtl/sop_literal_gen.sv
module sop_literal_gen #(
    parameter int N_LINE = 26,
    localparam int N_LIT = 2 * N_LINE
) (
    input  logic [N_LINE-1:0] lines,
    output logic [N_LIT-1:0]  lits
);
    for (genvar k = 0; k < N_LINE; k++) begin : g_pair
        assign lits[2*k]   = lines[k];
        assign lits[2*k+1] = ~lines[k];
    end
endmodule

// File: rtl/sop_product_term.sv
module sop_product_term #(
    parameter int N_LIT = 52
) (
    input  logic [N_LIT-1:0] conn,
    input  logic [N_LIT-1:0] lits,
    output logic             term_hi
);
    // Unconnected literals pass as 1; an empty term therefore reads high
    assign term_hi = &(~conn | lits);
endmodule

// File: rtl/sop_or_group.sv
module sop_or_group #(
    parameter int N_T = 8
) (
    input  logic [N_T-1:0] terms,
    output logic           sum
);
    assign sum = |terms;
endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
(
    input  logic [N_DED-1:0]  ded_in,
    input  logic [N_FB-1:0]   fb_in,
    input  logic [FUSE_W-1:0] cfg_fuses,
    output logic [N_OUT-1:0]  sum_out
);
    line_bus_t          line_s;
    logic [N_LIT-1:0]   lits;
    logic [N_TERM-1:0]  term_hi;

    assign line_s.ded = ded_in;
    assign line_s.fb  = fb_in;

    sop_literal_gen #(.N_LINE(N_LINE)) u_lits (
        .lines (line_s),
        .lits  (lits)
    );

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        sop_product_term #(.N_LIT(N_LIT)) u_pt (
            .conn    (cfg_fuses[t*N_LIT +: N_LIT]),
            .lits    (lits),
            .term_hi (term_hi[t])
        );
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam int BASE = base_of(o);
        localparam int CNT  = terms_of(o);
        sop_or_group #(.N_T(CNT)) u_or (
            .terms (term_hi[BASE +: CNT]),
            .sum   (sum_out[o])
        );
    end
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk
    import sop_pkg::*;
(
    input logic [FUSE_W-1:0] cfg_fuses,
    input logic [N_TERM-1:0] term_hi,
    input logic [N_OUT-1:0]  sum_out
);
    always_comb begin
        for (int t = 0; t < N_TERM; t++) begin
            logic [N_LIT-1:0] c;
            logic clash;
            c = cfg_fuses[t*N_LIT +: N_LIT];
            clash = 1'b0;
            for (int k = 0; k < N_LINE; k++) clash |= c[2*k] & c[2*k+1];
            if (c == '0)
                a_r3_empty_term_high: assert (term_hi[t]);
            if (clash)
                a_r4_clash_term_low: assert (!term_hi[t]);
        end
        for (int o = 0; o < N_OUT; o++) begin
            logic any_hi;
            any_hi = 1'b0;
            for (int j = 0; j < terms_of(o); j++) any_hi |= term_hi[base_of(o) + j];
            // R6: a sum is high exactly when one of its own terms is high
            a_r6_sum_from_own_terms: assert (sum_out[o] == any_hi);
            if (any_hi)
                a_r5_group_term_drives_sum: assert (sum_out[o]);
        end
    end
endmodule

bind sop_array sop_array_chk chk_i (
    .cfg_fuses (cfg_fuses),
    .term_hi   (term_hi),
    .sum_out   (sum_out)
);

// File: tb/sop_array_tb_top.sv
module sop_array_tb_top;
    import sop_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;
    localparam int TC [12] = '{8, 8, 10, 12, 14, 16, 16, 14, 12, 10, 8, 8};

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [N_DED-1:0]  ded_in;
    logic [N_FB-1:0]   fb_in;
    logic [FUSE_W-1:0] fuse;
    logic [N_OUT-1:0]  sum_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    sop_array dut_i (
        .ded_in    (ded_in),
        .fb_in     (fb_in),
        .cfg_fuses (fuse),
        .sum_out   (sum_out)
    );

    function automatic int tbase(input int o);
        int a = 0;
        for (int i = 0; i < o; i++) a += TC[i];
        return a;
    endfunction

    function automatic logic [11:0] model(input logic [13:0] d, input logic [11:0] f,
                                          input logic [FUSE_W-1:0] m);
        logic [25:0] ln;
        logic [11:0] r;
        int t;
        ln = {f, d};
        r = '0;
        t = 0;
        for (int o = 0; o < 12; o++) begin
            for (int j = 0; j < TC[o]; j++) begin
                logic p;
                p = 1'b1;
                for (int k = 0; k < 26; k++) begin
                    if (m[t*52 + 2*k]     && !ln[k]) p = 1'b0;
                    if (m[t*52 + 2*k + 1] &&  ln[k]) p = 1'b0;
                end
                r[o] |= p;
                t++;
            end
        end
        return r;
    endfunction

    task automatic check(input string req);
        logic [11:0] exp_v;
        #1;
        exp_v = model(ded_in, fb_in, fuse);
        checks++;
        if (sum_out !== exp_v) begin
            errors++;
            $display("FAIL %s: sum_out=%h expected=%h", req, sum_out, exp_v);
        end
    endtask

    task automatic clash_term(input int t);
        fuse[t*52 +: 52] = '0;
        fuse[t*52]       = 1'b1;
        fuse[t*52 + 1]   = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        ded_in = '0; fb_in = '0; fuse = '0;
        @(negedge clk);

        // R3: unprogrammed map gives all ones regardless of inputs
        check("R3");
        ded_in = '1; fb_in = '1; check("R3");
        ded_in = 14'h2a5a; fb_in = 12'h5a3; check("R3");
        #1 checks++;
        if (sum_out !== 12'hfff) begin
            errors++;
            $display("FAIL R3: sum_out=%h expected=fff", sum_out);
        end

        // R1 R2 R7 R8: single literal per output, both polarities, both values
        for (int o = 0; o < 12; o++) begin
            for (int k = 0; k < 26; k++) begin
                for (int p = 0; p < 2; p++) begin
                    fuse = '0;
                    for (int j = 1; j < TC[o]; j++) clash_term(tbase(o) + j);
                    fuse[tbase(o)*52 + 2*k + p] = 1'b1;
                    for (int v = 0; v < 2; v++) begin
                        ded_in = '0; fb_in = '0;
                        if (k < 14) ded_in[k] = v[0]; else fb_in[k-14] = v[0];
                        check("R1/R2 line map");
                        checks++;
                        if (sum_out[o] !== (v[0] ^ p[0])) begin
                            errors++;
                            $display("FAIL R7: out%0d=%b expected=%b", o, sum_out[o], v[0] ^ p[0]);
                        end
                    end
                end
            end
            @(negedge clk);
        end

        // R4 R5 R6: all terms stuck low, then release one at a time
        ded_in = 14'h1234; fb_in = 12'hc3a;
        for (int o = 0; o < 12; o++) begin
            fuse = '0;
            for (int j = 0; j < TC[o]; j++) clash_term(tbase(o) + j);
            check("R4");
            checks++;
            if (sum_out !== ~(12'h1 << o)) begin
                errors++;
                $display("FAIL R4: sum_out=%h expected=%h", sum_out, ~(12'h1 << o));
            end
            for (int j = 0; j < TC[o]; j++) begin
                fuse[(tbase(o)+j)*52 +: 52] = '0;
                check("R5");
                checks++;
                if (sum_out !== 12'hfff) begin
                    errors++;
                    $display("FAIL R5: sum_out=%h expected=fff", sum_out);
                end
                clash_term(tbase(o) + j);
            end
            @(negedge clk);
        end

        // R6: whole array stuck low, neighbour terms released at group edges
        fuse = '0;
        for (int t = 0; t < N_TERM; t++) clash_term(t);
        check("R6");
        for (int o = 0; o < 12; o++) begin
            fuse[tbase(o)*52 +: 52] = '0;
            check("R6 first term");
            clash_term(tbase(o));
            fuse[(tbase(o)+TC[o]-1)*52 +: 52] = '0;
            check("R6 last term");
            clash_term(tbase(o) + TC[o] - 1);
        end

        // R7 R6: sparse random maps against the model
        for (int n = 0; n < 150; n++) begin
            for (int b = 0; b < FUSE_W; b++) fuse[b] = (($urandom % 20) == 0);
            for (int r = 0; r < 4; r++) begin
                ded_in = 14'($urandom);
                fb_in  = 12'($urandom);
                check("R7 random");
            end
            @(negedge clk);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule